// File: doc/BRIEF.md
# Streaming Pixel Lookup-Table Transform

This block remaps a raster stream of 8-bit unsigned samples through a programmable table of 256 one-byte entries. Each output byte is the table entry addressed by the corresponding input byte. Pixels enter and leave on valid/ready streams. A beat carries either 1 or 8 pixels, and each pixel has either 1 or 3 channel bytes. The output frame has the same size and pixel format as the input frame.

The table is loaded through a simple write port while the stream is idle. Every parallel lookup lane holds its own copy of the table, so a full beat is translated in a single cycle. Each write updates every copy. A write issued while a frame is in progress is dropped, and a sticky error flag records it.

Row and column counters count the accepted beats. From them the block tags the last beat of every row and the last beat of the frame. After reset the table holds the identity mapping, so an unprogrammed block passes pixels through unchanged.

Top module: `pix_remap`

## Requirements
- R1: Every byte lane of an output beat equals table[input byte of the same lane], using a table of 256 eight-bit unsigned entries.
- R2: After reset the table holds the identity mapping (entry i = i). After reset, m_valid and tw_err are 0 and s_ready is 1.
- R3: A beat carries PIX_PER_BEAT×CHANNELS byte lanes. Lane k = pixel*CHANNELS + channel sits at bits [8k+7:8k]. The same table is applied to every channel byte independently.
- R4: PIX_PER_BEAT is a parameter restricted to 1 or 8. All lanes of a beat are translated in the same cycle.
- R5: A table write (tw_en high with tw_addr and tw_data) taken while the stream is idle updates every lane copy. It applies to all frames that follow.
- R6: The stream counts as busy from the first beat of a frame until its last beat has left the output. A table write while busy is ignored, and it sets tw_err, which stays high until reset.
- R7: With m_ready held high, a beat presented and accepted in cycle n appears with m_valid high in cycle n+2, and m_valid is low in cycle n+1.
- R8: While m_valid is high and m_ready is low, m_data, m_eol and m_eof hold steady. Every accepted beat leaves exactly once and in order.
- R9: m_eol is high on the last beat of each row, which is beat COLS/PIX_PER_BEAT-1 of the row, and low on all other beats.
- R10: m_eof is high only on the last beat of row ROWS-1, together with m_eol. The next beat starts a new frame at row 0.
- R11: At elaboration, CHANNELS must be 1 or 3 and COLS must be a whole multiple of PIX_PER_BEAT.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| tw_en | input | 1 | Table write strobe |
| tw_addr | input | 8 | Table entry index |
| tw_data | input | 8 | Value to store |
| tw_err | output | 1 | Sticky flag: a write arrived while the stream was busy |
| s_valid | input | 1 | Input beat valid |
| s_ready | output | 1 | Block can take an input beat |
| s_data | input | 8*PIX_PER_BEAT*CHANNELS | Input pixel bytes |
| m_valid | output | 1 | Output beat valid |
| m_ready | input | 1 | Downstream can take an output beat |
| m_data | output | 8*PIX_PER_BEAT*CHANNELS | Remapped pixel bytes |
| m_eol | output | 1 | Last beat of a row |
| m_eof | output | 1 | Last beat of the frame |

## Verification
The lookup is run through four tables and four input patterns:
- The identity table with a lane-indexed ramp shows that lanes are neither swapped nor misaligned.
- An inverting table on all-zero and all-ones beats exercises both ends of the address range.
- A scrambling table on random bytes, under random output stalls, separates per-lane lookup from any shared-port or hold error.
- A write slipped into the middle of a frame, followed by a check that the old mapping persists, shows whether the idle guard works.

// File: rtl/pix_remap_pkg.sv
package pix_remap_pkg;
   localparam int SAMPLE_W = 8;
   localparam int TBL_AW   = 8;
   localparam int TBL_DEPTH = 1 << TBL_AW;

   function automatic int lane_count(input int ppb, input int nch);
      return ppb * nch;
   endfunction
endpackage

// File: rtl/pix_remap_tbl.sv
module pix_remap_tbl #(
   parameter int DW = 8,
   parameter int AW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          we,
   input  logic [AW-1:0] waddr,
   input  logic [DW-1:0] wdata,
   input  logic          re,
   input  logic [AW-1:0] raddr,
   output logic [DW-1:0] rdata
);
   localparam int DEPTH = 1 << AW;

   logic [DW-1:0] mem [DEPTH];

   // identity contents after reset
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) mem[i] <= DW'(i);
      end else if (we) begin
         mem[waddr] <= wdata;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  rdata <= '0;
      else if (re) rdata <= mem[raddr];
   end
endmodule

// File: rtl/pix_remap_cnt.sv
module pix_remap_cnt #(
   parameter int ROWS  = 4,
   parameter int BEATS = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic step,
   output logic last_col,
   output logic last_row,
   output logic at_start
);
   localparam int CW = (BEATS > 1) ? $clog2(BEATS) : 1;
   localparam int RW = (ROWS  > 1) ? $clog2(ROWS)  : 1;

   logic [CW-1:0] col_q;
   logic [RW-1:0] row_q;

   assign last_col = (col_q == CW'(BEATS - 1));
   assign last_row = (row_q == RW'(ROWS - 1));
   assign at_start = (col_q == '0) && (row_q == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         col_q <= '0;
         row_q <= '0;
      end else if (step) begin
         if (last_col) begin
            col_q <= '0;
            row_q <= last_row ? '0 : row_q + RW'(1);
         end else begin
            col_q <= col_q + CW'(1);
         end
      end
   end
endmodule

// File: rtl/pix_remap.sv
module pix_remap
   import pix_remap_pkg::*;
#(
   parameter int PIX_PER_BEAT = 8,
   parameter int CHANNELS     = 1,
   parameter int ROWS         = 1080,
   parameter int COLS         = 1920,
   localparam int LANES       = PIX_PER_BEAT * CHANNELS,
   localparam int BW          = LANES * SAMPLE_W
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                tw_en,
   input  logic [TBL_AW-1:0]   tw_addr,
   input  logic [SAMPLE_W-1:0] tw_data,
   output logic                tw_err,
   input  logic                s_valid,
   output logic                s_ready,
   input  logic [BW-1:0]       s_data,
   output logic                m_valid,
   input  logic                m_ready,
   output logic [BW-1:0]       m_data,
   output logic                m_eol,
   output logic                m_eof
);
   localparam int BEATS = COLS / PIX_PER_BEAT;

   // R11 elaboration checks
   if (PIX_PER_BEAT != 1 && PIX_PER_BEAT != 8) begin : g_bad_ppb
      $error("pix_remap: PIX_PER_BEAT must be 1 or 8");
   end
   if (CHANNELS != 1 && CHANNELS != 3) begin : g_bad_nch
      $error("pix_remap: CHANNELS must be 1 or 3");
   end
   if (COLS % PIX_PER_BEAT != 0) begin : g_bad_cols
      $error("pix_remap: COLS must be a multiple of PIX_PER_BEAT");
   end
   if (ROWS < 1 || BEATS < 1) begin : g_bad_size
      $error("pix_remap: frame must hold at least one beat");
   end

   logic advance, accept;
   logic last_col, last_row, at_start;
   logic v1_q, eol1_q, eof1_q;
   logic v2_q, eol2_q, eof2_q;
   logic [BW-1:0] d1_q;
   logic busy, wr_ok;
   logic err_q;

   // one global stall: the pipeline moves when the output slot frees
   assign advance = !v2_q || m_ready;
   assign s_ready = advance;
   assign accept  = s_valid && advance;

   pix_remap_cnt #(
      .ROWS (ROWS),
      .BEATS(BEATS)
   ) cnt_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .step    (accept),
      .last_col(last_col),
      .last_row(last_row),
      .at_start(at_start)
   );

   // stage 1: capture the beat and its position tags
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         v1_q   <= 1'b0;
         eol1_q <= 1'b0;
         eof1_q <= 1'b0;
         d1_q   <= '0;
      end else if (advance) begin
         v1_q   <= s_valid;
         eol1_q <= s_valid && last_col;
         eof1_q <= s_valid && last_col && last_row;
         if (s_valid) d1_q <= s_data;
      end
   end

   // stage 2: tags travel alongside the registered table read
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         v2_q   <= 1'b0;
         eol2_q <= 1'b0;
         eof2_q <= 1'b0;
      end else if (advance) begin
         v2_q   <= v1_q;
         eol2_q <= eol1_q;
         eof2_q <= eof1_q;
      end
   end

   // table guard
   assign busy  = v1_q || v2_q || !at_start;
   assign wr_ok = tw_en && !busy;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)               err_q <= 1'b0;
      else if (tw_en && busy)   err_q <= 1'b1;
   end

   // one table copy per byte lane
   for (genvar k = 0; k < LANES; k++) begin : g_lane
      pix_remap_tbl #(
         .DW(SAMPLE_W),
         .AW(TBL_AW)
      ) tbl_i (
         .clk  (clk),
         .rst_n(rst_n),
         .we   (wr_ok),
         .waddr(tw_addr),
         .wdata(tw_data),
         .re   (advance && v1_q),
         .raddr(d1_q[k*SAMPLE_W +: TBL_AW]),
         .rdata(m_data[k*SAMPLE_W +: SAMPLE_W])
      );
   end

   assign m_valid = v2_q;
   assign m_eol   = eol2_q;
   assign m_eof   = eof2_q;
   assign tw_err  = err_q;
endmodule

// File: rtl/pix_remap_chk.sv
module pix_remap_chk #(
   parameter int BW = 8
) (
   input logic          clk,
   input logic          rst_n,
   input logic          tw_en,
   input logic          tw_err,
   input logic          s_ready,
   input logic          m_valid,
   input logic          m_ready,
   input logic [BW-1:0] m_data,
   input logic          m_eol,
   input logic          m_eof
);
   assert_hold_on_stall_R8: assert property (@(posedge clk) disable iff (!rst_n)
      m_valid && !m_ready |=> m_valid && $stable(m_data) && $stable(m_eol) && $stable(m_eof));

   assert_eof_with_eol_R10: assert property (@(posedge clk) disable iff (!rst_n)
      m_valid && m_eof |-> m_eol);

   assert_err_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
      tw_err |=> tw_err);

   assert_err_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(tw_err) |-> $past(tw_en));

   assert_busy_write_flags_R6: assert property (@(posedge clk) disable iff (!rst_n)
      tw_en && m_valid |=> tw_err);

   assert_empty_accepts_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !m_valid |-> s_ready);
endmodule

bind pix_remap pix_remap_chk #(.BW(BW)) chk_i (
   .clk    (clk),
   .rst_n  (rst_n),
   .tw_en  (tw_en),
   .tw_err (tw_err),
   .s_ready(s_ready),
   .m_valid(m_valid),
   .m_ready(m_ready),
   .m_data (m_data),
   .m_eol  (m_eol),
   .m_eof  (m_eof)
);

// File: tb/pix_remap_tb_top.sv
module pix_remap_tb_top;
   localparam int PPB   = 8;
   localparam int NCH   = 3;
   localparam int ROWS  = 3;
   localparam int COLS  = 16;
   localparam int LANES = PPB * NCH;
   localparam int W     = LANES * 8;
   localparam int BPR   = COLS / PPB;
   localparam int BPF   = BPR * ROWS;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic tw_en = 1'b0;
   logic [7:0] tw_addr = '0, tw_data = '0;
   logic tw_err, s_ready, m_valid, m_eol, m_eof;
   logic s_valid = 1'b0;
   logic m_ready = 1'b1;
   logic [W-1:0] s_data = '0;
   logic [W-1:0] m_data;

   int checks = 0, fails = 0, cyc = 0;
   bit bp_mode = 1'b0;
   logic [7:0] ref_tbl [256];
   logic [W+1:0] expq [$];

   always #5 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   pix_remap #(.PIX_PER_BEAT(PPB), .CHANNELS(NCH), .ROWS(ROWS), .COLS(COLS)) dut_i (
      .clk(clk), .rst_n(rst_n), .tw_en(tw_en), .tw_addr(tw_addr), .tw_data(tw_data),
      .tw_err(tw_err), .s_valid(s_valid), .s_ready(s_ready), .s_data(s_data),
      .m_valid(m_valid), .m_ready(m_ready), .m_data(m_data), .m_eol(m_eol), .m_eof(m_eof));

   task automatic chk(input bit ok, input string req, input logic [W+1:0] act, input logic [W+1:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s act=%h exp=%h", req, act, exp);
      end
   endtask

   function automatic logic [W-1:0] remap(input logic [W-1:0] d);
      logic [W-1:0] r;
      for (int k = 0; k < LANES; k++) r[k*8 +: 8] = ref_tbl[d[k*8 +: 8]];
      return r;
   endfunction

   always @(negedge clk) m_ready <= bp_mode ? 1'($urandom % 2) : 1'b1;

   // monitor: pops the scoreboard at every output handshake
   initial begin
      forever begin
         @(negedge clk);
         #3;
         if (rst_n && m_valid && m_ready) begin
            if (expq.size() == 0) begin
               chk(1'b0, "R8 extra beat", {m_eol, m_eof, m_data}, '0);
            end else begin
               logic [W+1:0] e;
               e = expq.pop_front();
               chk(e == {m_eol, m_eof, m_data}, "R1 R3 R9 R10 beat", {m_eol, m_eof, m_data}, e);
            end
         end
      end
   end

   task automatic do_reset();
      rst_n = 1'b0;
      repeat (3) @(posedge clk);
      for (int i = 0; i < 256; i++) ref_tbl[i] = 8'(i);
      expq.delete();
      @(negedge clk);
      rst_n = 1'b1;
   endtask

   task automatic wr_tbl(input logic [7:0] a, input logic [7:0] d, input bit apply);
      @(negedge clk);
      tw_en = 1'b1; tw_addr = a; tw_data = d;
      @(posedge clk);
      #1 tw_en = 1'b0;
      if (apply) ref_tbl[a] = d;
   endtask

   task automatic send_beat(input logic [W-1:0] d, input int idx);
      bit eol, eof;
      eol = (idx % BPR) == BPR - 1;
      eof = (idx == BPF - 1);
      @(negedge clk);
      s_valid = 1'b1; s_data = d;
      #3;
      while (!s_ready) begin
         @(negedge clk);
         #3;
      end
      expq.push_back({eol, eof, remap(d)});
      @(posedge clk);
      #1 s_valid = 1'b0;
   endtask

   // pattern: 0 lane ramp, 1 random, 2 all zero, 3 all ones
   function automatic logic [W-1:0] make_beat(input int pat, input int idx);
      logic [W-1:0] d;
      for (int k = 0; k < LANES; k++)
         case (pat)
            0: d[k*8 +: 8] = 8'(idx * LANES + k);
            1: d[k*8 +: 8] = 8'($urandom);
            2: d[k*8 +: 8] = 8'h00;
            default: d[k*8 +: 8] = 8'hFF;
         endcase
      return d;
   endfunction

   task automatic send_frame(input int pat);
      for (int b = 0; b < BPF; b++) send_beat(make_beat(pat, b), b);
   endtask

   task automatic drain();
      int n = 0;
      while ((expq.size() != 0 || m_valid) && n < 1000) begin
         @(negedge clk);
         n++;
      end
      repeat (3) @(negedge clk);
      chk(expq.size() == 0, "R8 all beats delivered", W'(expq.size()), '0);
   endtask

   initial begin
      logic [W-1:0] d0;
      do_reset();
      #3;
      chk(m_valid == 1'b0, "R2 m_valid after reset", m_valid, 0);
      chk(tw_err == 1'b0, "R2 tw_err after reset", tw_err, 0);
      chk(s_ready == 1'b1, "R2 s_ready after reset", s_ready, 1);

      // R7 latency on first beat, identity table (R2)
      d0 = make_beat(0, 0);
      @(negedge clk);
      s_valid = 1'b1; s_data = d0;
      expq.push_back({1'b0, 1'b0, remap(d0)});
      @(posedge clk);
      #1 s_valid = 1'b0;
      @(negedge clk); #3;
      chk(m_valid == 1'b0, "R7 not valid in cycle n+1", m_valid, 0);
      @(negedge clk); #3;
      chk(m_valid == 1'b1, "R7 valid in cycle n+2", m_valid, 1);
      chk(m_data == d0, "R2 identity pass-through", m_data, d0);
      for (int b = 1; b < BPF; b++) send_beat(make_beat(0, b), b);
      drain();

      // R5 inverting table, boundary bytes (R4 all lanes in a beat)
      for (int i = 0; i < 256; i++) wr_tbl(8'(i), 8'(255 - i), 1'b1);
      chk(tw_err == 1'b0, "R5 idle writes raise no error", tw_err, 0);
      send_frame(2);
      send_frame(3);
      drain();

      // R5 scrambled table, random data under backpressure (R8)
      for (int i = 0; i < 256; i++) wr_tbl(8'(i), 8'(i * 7 + 3), 1'b1);
      bp_mode = 1'b1;
      send_frame(1);
      send_frame(0);
      send_frame(1);
      drain();
      bp_mode = 1'b0;

      // R6 write in mid-frame is dropped and flagged
      for (int b = 0; b < 2; b++) send_beat(make_beat(0, b), b);
      wr_tbl(8'h10, ~ref_tbl[8'h10], 1'b0);
      for (int b = 2; b < BPF; b++) send_beat(make_beat(0, b), b);
      drain();
      @(negedge clk); #3;
      chk(tw_err == 1'b1, "R6 tw_err set by busy write", tw_err, 1);
      send_frame(0);      // entry 0x10 must still hold its old value
      drain();
      chk(tw_err == 1'b1, "R6 tw_err stays set", tw_err, 1);

      do_reset();
      #3;
      chk(tw_err == 1'b0, "R2 tw_err cleared by reset", tw_err, 0);
      send_frame(1);
      drain();

      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      #(200000 * 10);
      fails++;
      checks++;
      $display("FAIL watchdog expired act=%0d exp=0", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule